// File: doc/BRIEF.md
# Receive character compare filter

This block sits behind the receive shift register of a serial port that works as a client. Each time the shifter finishes a character, up to 16 bits wide, it offers the character with a one-cycle valid strobe. The filter masks the character to the configured width and compares it with two programmable values. The ordering of the two values picks the test. If they are equal, the test is an exact match. If the first is lower, the test is an inclusive range. If the first is higher, the character must equal either of the two.

A match has one of two effects. In status mode, every character goes into the receive data register and a sticky compare flag records matches. Reading the status register clears that flag. In gate mode, characters are dropped until one matches. The matching character is the first one stored, and every later character is stored as well. A request-clear strobe closes the gate again. A one-cycle match pulse is also produced for each matching character, for use by a wake-up controller. In host mode, comparison is off: every character is stored and no match is ever reported.

Top module: `rx_cmp_filter`

## Requirements
- R1: With `client_en` low, every valid character is loaded, and neither `cmp_flag` nor `match_pulse` is set, whatever the gate mode.
- R2: When the masked `cmp_a` equals the masked `cmp_b`, a character matches only if it equals `cmp_a`.
- R3: When the masked `cmp_a` is below the masked `cmp_b`, a character matches if it lies from `cmp_a` to `cmp_b`, both ends included.
- R4: When the masked `cmp_a` is above the masked `cmp_b`, a character matches only if it equals one of the two values.
- R5: The character and both compare values are masked to `char_len` bits. A value of `char_len` below 8 acts as 8, and a value above 16 acts as 16. `rdr_data` holds the masked character.
- R6: In status mode (`gate_mode` = 0), each valid character is written to `rdr_data` on the clock edge that samples it. `cmp_flag` rises on that same edge when the character matches.
- R7: `status_rd` clears `cmp_flag` on the next edge. If a match arrives in the same cycle, the flag stays at 1.
- R8: In gate mode, with the gate closed, non-matching characters leave `rdr_data` and `rdr_full` unchanged. The matching character is stored, the gate opens, and all later characters are stored.
- R9: A `req_clr` pulse closes the gate from the next cycle onward, so loading stops until the next match.
- R10: `rdr_full` sets on every load and clears on `rdr_rd`. A load in the same cycle as `rdr_rd` leaves it at 1.
- R11: `match_pulse` is high for exactly the one cycle after each matching character, in both modes.
- R12: After reset, `rdr_data`, `rdr_full`, `cmp_flag` and `match_pulse` are 0 and the gate is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Completed character strobe |
| rx_char | input | 16 | Received character |
| cmp_a | input | 16 | First compare value |
| cmp_b | input | 16 | Second compare value |
| char_len | input | 5 | Character width in bits (8 to 16, clamped) |
| gate_mode | input | 1 | 1 = match gates loading, 0 = match sets flag only |
| client_en | input | 1 | 1 = client mode, comparison active |
| status_rd | input | 1 | Status-read strobe, clears compare flag |
| req_clr | input | 1 | Re-arms the load gate |
| rdr_rd | input | 1 | Receive-data read strobe, clears data-ready |
| rdr_data | output | 16 | Receive data register |
| rdr_full | output | 1 | Data-ready flag |
| cmp_flag | output | 1 | Sticky compare flag |
| match_pulse | output | 1 | One-cycle pulse per matching character |

## Verification
The gate state is hidden, so a wrong value appears only when the next character arrives. If the gate is wrongly open, `rdr_data` and `rdr_full` change for a character that should have been dropped. If it is wrongly closed, a character that should have been stored is lost. Either fault shows one edge after that character's strobe.

A wrong mode decode or a wrong mask shows at once in `match_pulse`, one cycle after the character. It also shows in `cmp_flag` on the same edge. A wrong flag state persists until the next status read, so the bench compares all four outputs after every cycle.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  typedef enum logic [1:0] {
    CK_EXACT = 2'd0,
    CK_RANGE = 2'd1,
    CK_PAIR  = 2'd2
  } cmp_kind_e;
endpackage

// File: rtl/rxc_matcher.sv
module rxc_matcher #(
  parameter int CHAR_W = 16,
  parameter int MIN_W  = 8,
  parameter int LEN_W  = 5
) (
  input  logic [CHAR_W-1:0] rx_char,
  input  logic [CHAR_W-1:0] cmp_a,
  input  logic [CHAR_W-1:0] cmp_b,
  input  logic [LEN_W-1:0]  char_len,
  output logic [CHAR_W-1:0] char_masked,
  output logic              hit_raw
);
  import rxc_pkg::*;

  function automatic int clamp_len(input logic [LEN_W-1:0] len);
    int l;
    l = int'(len);
    if (l < MIN_W) l = MIN_W;
    if (l > CHAR_W) l = CHAR_W;
    return l;
  endfunction

  function automatic logic [CHAR_W-1:0] width_mask(input int w);
    logic [CHAR_W-1:0] m;
    for (int i = 0; i < CHAR_W; i++) m[i] = (i < w);
    return m;
  endfunction

  function automatic cmp_kind_e kind_of(input logic [CHAR_W-1:0] a,
                                        input logic [CHAR_W-1:0] b);
    if (a == b) return CK_EXACT;
    else if (a < b) return CK_RANGE;
    else return CK_PAIR;
  endfunction

  function automatic logic hit_of(input cmp_kind_e k,
                                  input logic [CHAR_W-1:0] c,
                                  input logic [CHAR_W-1:0] a,
                                  input logic [CHAR_W-1:0] b);
    case (k)
      CK_EXACT: return c == a;
      CK_RANGE: return (c >= a) && (c <= b);
      default:  return (c == a) || (c == b);
    endcase
  endfunction

  logic [CHAR_W-1:0] mask;
  logic [CHAR_W-1:0] a_m;
  logic [CHAR_W-1:0] b_m;
  cmp_kind_e         kind;

  always_comb begin
    mask        = width_mask(clamp_len(char_len));
    char_masked = rx_char & mask;
    a_m         = cmp_a & mask;
    b_m         = cmp_b & mask;
    kind        = kind_of(a_m, b_m);
    hit_raw     = hit_of(kind, char_masked, a_m, b_m);
  end
endmodule

// File: rtl/rxc_gate.sv
module rxc_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic client_en,
  input  logic gate_mode,
  input  logic rx_valid,
  input  logic hit,
  input  logic req_clr,
  output logic load,
  output logic gate_open
);
  logic gated;

  assign gated = client_en & gate_mode;
  assign load  = rx_valid & (~gated | gate_open | hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_open <= 1'b0;
    else        gate_open <= (gate_open & ~req_clr) | (hit & gate_mode);
  end
endmodule

// File: rtl/rxc_status.sv
module rxc_status #(
  parameter int CHAR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              hit,
  input  logic [CHAR_W-1:0] char_masked,
  input  logic              status_rd,
  input  logic              rdr_rd,
  output logic [CHAR_W-1:0] rdr_data,
  output logic              rdr_full,
  output logic              cmp_flag,
  output logic              match_pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdr_data    <= '0;
      rdr_full    <= 1'b0;
      cmp_flag    <= 1'b0;
      match_pulse <= 1'b0;
    end else begin
      if (load) rdr_data <= char_masked;
      rdr_full    <= load | (rdr_full & ~rdr_rd);
      cmp_flag    <= hit | (cmp_flag & ~status_rd);
      match_pulse <= hit;
    end
  end
endmodule

// File: rtl/rx_cmp_filter.sv
module rx_cmp_filter #(
  parameter int CHAR_W = 16,
  parameter int MIN_W  = 8,
  parameter int LEN_W  = $clog2(CHAR_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic [CHAR_W-1:0] cmp_a,
  input  logic [CHAR_W-1:0] cmp_b,
  input  logic [LEN_W-1:0]  char_len,
  input  logic              gate_mode,
  input  logic              client_en,
  input  logic              status_rd,
  input  logic              req_clr,
  input  logic              rdr_rd,
  output logic [CHAR_W-1:0] rdr_data,
  output logic              rdr_full,
  output logic              cmp_flag,
  output logic              match_pulse
);
  logic [CHAR_W-1:0] char_masked;
  logic              hit_raw;
  logic              hit;
  logic              load;
  logic              gate_open;

  rxc_matcher #(.CHAR_W(CHAR_W), .MIN_W(MIN_W), .LEN_W(LEN_W)) u_match (
    .rx_char    (rx_char),
    .cmp_a      (cmp_a),
    .cmp_b      (cmp_b),
    .char_len   (char_len),
    .char_masked(char_masked),
    .hit_raw    (hit_raw)
  );

  assign hit = rx_valid & client_en & hit_raw;

  rxc_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .client_en(client_en),
    .gate_mode(gate_mode),
    .rx_valid (rx_valid),
    .hit      (hit),
    .req_clr  (req_clr),
    .load     (load),
    .gate_open(gate_open)
  );

  rxc_status #(.CHAR_W(CHAR_W)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .hit        (hit),
    .char_masked(char_masked),
    .status_rd  (status_rd),
    .rdr_rd     (rdr_rd),
    .rdr_data   (rdr_data),
    .rdr_full   (rdr_full),
    .cmp_flag   (cmp_flag),
    .match_pulse(match_pulse)
  );
endmodule

// File: rtl/rx_cmp_filter_chk.sv
module rx_cmp_filter_chk #(
  parameter int CHAR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              gate_mode,
  input logic              client_en,
  input logic              status_rd,
  input logic              req_clr,
  input logic              rdr_rd,
  input logic [CHAR_W-1:0] char_masked,
  input logic [CHAR_W-1:0] rdr_data,
  input logic              rdr_full,
  input logic              cmp_flag,
  input logic              match_pulse,
  input logic              hit,
  input logic              gate_open
);
  p_host_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !client_en) |=> (!match_pulse && rdr_full));

  p_status_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !gate_mode) |=> (rdr_data == $past(char_masked)));

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> cmp_flag);

  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !hit) |=> !cmp_flag);

  p_gate_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && client_en && gate_mode && !gate_open && !hit)
      |=> ($stable(rdr_data) && rdr_full == $past(rdr_full && !rdr_rd)));

  p_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_clr && !hit) |=> !gate_open);

  p_ready_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rdr_rd && !rx_valid) |=> !rdr_full);

  p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> $past(hit));
endmodule

bind rx_cmp_filter rx_cmp_filter_chk #(.CHAR_W(CHAR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_valid   (rx_valid),
  .gate_mode  (gate_mode),
  .client_en  (client_en),
  .status_rd  (status_rd),
  .req_clr    (req_clr),
  .rdr_rd     (rdr_rd),
  .char_masked(char_masked),
  .rdr_data   (rdr_data),
  .rdr_full   (rdr_full),
  .cmp_flag   (cmp_flag),
  .match_pulse(match_pulse),
  .hit        (hit),
  .gate_open  (gate_open)
);

// File: tb/rx_cmp_filter_bench.sv
module rx_cmp_filter_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [15:0] rx_char = '0;
  logic [15:0] cmp_a = '0;
  logic [15:0] cmp_b = '0;
  logic [4:0]  char_len = 5'd8;
  logic        gate_mode = 1'b0;
  logic        client_en = 1'b1;
  logic        status_rd = 1'b0;
  logic        req_clr = 1'b0;
  logic        rdr_rd = 1'b0;
  logic [15:0] rdr_data;
  logic        rdr_full;
  logic        cmp_flag;
  logic        match_pulse;

  int checks = 0;
  int errors = 0;

  logic [15:0] e_rdr = '0;
  logic        e_full = 1'b0;
  logic        e_flag = 1'b0;
  logic        e_pulse = 1'b0;
  logic        e_gate = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  rx_cmp_filter u_rx_cmp_filter (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .char_len(char_len), .gate_mode(gate_mode),
    .client_en(client_en), .status_rd(status_rd), .req_clr(req_clr),
    .rdr_rd(rdr_rd), .rdr_data(rdr_data), .rdr_full(rdr_full),
    .cmp_flag(cmp_flag), .match_pulse(match_pulse)
  );

  function automatic int eff_bits(input int len);
    return (len < 8) ? 8 : ((len > 16) ? 16 : len);
  endfunction

  function automatic int low_bits(input int v, input int len);
    return v % (1 << eff_bits(len));
  endfunction

  function automatic bit ref_hit(input int ch, input int a, input int b, input int len);
    int c, x, y;
    c = low_bits(ch, len);
    x = low_bits(a, len);
    y = low_bits(b, len);
    if (x > y) return (c == x) || (c == y);
    if (x < y) return !(c < x) && !(c > y);
    return c == x;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit v, input int ch,
                      input bit srd, input bit rclr, input bit rrd);
    bit h, ld;
    rx_valid  = v;
    rx_char   = ch[15:0];
    status_rd = srd;
    req_clr   = rclr;
    rdr_rd    = rrd;
    h  = v && client_en && ref_hit(ch, cmp_a, cmp_b, char_len);
    ld = v && (!client_en || !gate_mode || e_gate || h);
    if (ld) e_rdr = 16'(low_bits(ch, char_len));
    e_full  = ld || (e_full && !rrd);
    e_flag  = h || (e_flag && !srd);
    e_pulse = h;
    e_gate  = (e_gate && !rclr) || (h && gate_mode);
    @(posedge clk);
    #1;
    chk(tag, "rdr_data", rdr_data, e_rdr);
    chk(tag, "rdr_full", rdr_full, e_full);
    chk(tag, "cmp_flag", cmp_flag, e_flag);
    chk(tag, "match_pulse", match_pulse, e_pulse);
  endtask

  task automatic cfg(input int a, input int b, input int len, input bit gm, input bit cl);
    cmp_a = a[15:0]; cmp_b = b[15:0]; char_len = len[4:0];
    gate_mode = gm; client_en = cl;
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R12", "rdr_data", rdr_data, 0);
    chk("R12", "rdr_full", rdr_full, 0);
    chk("R12", "cmp_flag", cmp_flag, 0);
    chk("R12", "match_pulse", match_pulse, 0);
    rst_n = 1'b1;

    // R2 exact value
    cfg(16'h55, 16'h55, 8, 0, 1);
    step("R2", 1, 16'h55, 0, 0, 0);
    step("R2", 1, 16'h54, 0, 0, 0);
    step("R11", 0, 0, 0, 0, 0);
    // R7 read clears, set wins
    step("R7", 0, 0, 1, 0, 0);
    step("R7", 1, 16'h55, 1, 0, 0);
    step("R7", 0, 0, 0, 0, 0);
    // R3 inclusive range
    cfg(16'h10, 16'h20, 8, 0, 1);
    step("R3", 1, 16'h10, 1, 0, 0);
    step("R3", 1, 16'h20, 1, 0, 0);
    step("R3", 1, 16'h15, 1, 0, 0);
    step("R3", 1, 16'h21, 1, 0, 0);
    step("R3", 1, 16'h0F, 1, 0, 0);
    // R4 two values
    cfg(16'h30, 16'h05, 8, 0, 1);
    step("R4", 1, 16'h30, 1, 0, 0);
    step("R4", 1, 16'h05, 1, 0, 0);
    step("R4", 1, 16'h10, 1, 0, 0);
    // R5 masking and clamping
    cfg(16'h3A5, 16'h3A5, 8, 0, 1);
    step("R5", 1, 16'h1A5, 1, 0, 0);
    cfg(16'h3A5, 16'h1A5, 12, 0, 1);
    step("R5", 1, 16'hF1A5, 1, 0, 0);
    cfg(16'hBEEF, 16'hBEEF, 20, 0, 1);
    step("R5", 1, 16'hBEEF, 1, 0, 0);
    cfg(16'h12, 16'h12, 3, 0, 1);
    step("R5", 1, 16'h712, 1, 0, 0);
    // R10 data ready
    step("R10", 0, 0, 0, 0, 1);
    step("R10", 1, 16'h01, 0, 0, 1);
    step("R10", 0, 0, 0, 0, 1);
    // R8 gate mode
    cfg(16'h42, 16'h42, 8, 1, 1);
    step("R8", 1, 16'h11, 1, 1, 0);
    step("R8", 1, 16'h12, 0, 0, 0);
    step("R8", 1, 16'h42, 0, 0, 0);
    step("R8", 1, 16'h13, 0, 0, 1);
    step("R8", 1, 16'h14, 1, 0, 0);
    // R9 re-arm
    step("R9", 0, 0, 0, 1, 1);
    step("R9", 1, 16'h15, 0, 0, 0);
    step("R9", 1, 16'h42, 0, 0, 0);
    step("R9", 1, 16'h16, 0, 0, 0);
    step("R9", 0, 0, 0, 1, 0);
    // R1 host mode
    cfg(16'h42, 16'h42, 8, 1, 0);
    step("R1", 1, 16'h42, 1, 0, 0);
    step("R1", 1, 16'h99, 0, 0, 1);
    cfg(16'h42, 16'h42, 8, 0, 0);
    step("R1", 1, 16'h42, 0, 0, 0);
    // R6 random mix
    for (int i = 0; i < 2000; i++) begin
      int a, b, ch, sel;
      a = $urandom_range(0, 255);
      b = $urandom_range(0, 255);
      if (($urandom % 8) == 0) begin
        cfg(a, b, $urandom_range(0, 31), $urandom_range(0, 1), ($urandom % 6) != 0);
      end
      sel = $urandom_range(0, 3);
      ch = (sel == 0) ? int'(cmp_a) : (sel == 1) ? int'(cmp_b) : int'($urandom_range(0, 65535));
      step("R6", ($urandom % 4) != 0, ch, ($urandom % 3) == 0,
           ($urandom % 10) == 0, ($urandom % 3) == 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule